// File: doc/BRIEF.md
# Instruction Ring with Kill and Clog Control

This block is the instruction queue of a port controller. Fixed-width instructions arrive one at a time from the network through a ready/valid port. They are held in a circular buffer of parameterized depth. The oldest entry sits at the execution point. New entries are written at the insertion point, which is the ring position that follows the youngest stored entry and therefore wraps around to sit just behind the execution point.

Ordinary instructions at the execution point are offered to an external executor. The executor answers in one of two ways. It can retire the instruction, which removes it. It can requeue the instruction, which moves it from the execution point to the insertion point in a single step.

Three control kinds are handled inside the block:
- A clog at the execution point blocks the executor.
- A kill does not enter the ring. It parks at the insertion point and removes consecutive non-clog entries from the execution point, one per cycle.
- An unclog also parks at the insertion point. It waits until a clog reaches the execution point, and then both are removed together.

Top module: `instr_ring`

## Requirements
- R1: After reset the ring is empty, `exec_valid` is low and `in_ready` is high.
- R2: The instruction kind is held in the two most significant bits: 00 is ordinary, 01 is kill, 10 is clog and 11 is unclog. The kill count is held in the low `KCW` bits of the instruction.
- R3: Ordinary instructions are presented on `exec_instr` in the order they were accepted. `exec_valid` is high only when the entry at the execution point is ordinary and no kill is parked.
- R4: While a clog occupies the execution point, `exec_valid` stays low. The clog remains in place until an unclog removes it.
- R5: An accepted unclog is parked, and `in_ready` stays low while it waits. The cycle after a clog is at the execution point, the clog and the unclog are both gone and the next entry is at the execution point.
- R6: An accepted kill with count c is parked, and `in_ready` and `exec_valid` stay low while it waits. It removes the next c+1 non-clog entries from the execution point, one per cycle, and then leaves the parked state.
- R7: A parked kill never removes a clog. It keeps waiting, and `in_ready` stays low.
- R8: A requeue moves the instruction at the execution point behind all stored entries. If an instruction is accepted in the same cycle, the requeued one is placed ahead of it.
- R9: A requeue while the ring is full has no effect, and the same instruction stays at the execution point.
- R10: `in_ready` is low whenever the ring holds `DEPTH` entries.
- R11: When `exec_retire` and `exec_requeue` are both asserted, the instruction is retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An incoming instruction is offered |
| in_ready | output | 1 | The ring can accept the offered instruction |
| in_instr | input | IW | Incoming instruction |
| exec_valid | output | 1 | An ordinary instruction is offered to the executor |
| exec_instr | output | IW | The instruction at the execution point |
| exec_retire | input | 1 | The executor is finished with the offered instruction |
| exec_requeue | input | 1 | The executor sends the offered instruction back to the insertion point |

## Verification
Several properties are checked on every clock cycle:
- The storage never overflows and never pops when it is empty.
- A clog at the execution point stays there unless an unclog pairs with it.
- A parked kill leaves the parked state exactly when its count runs out.
- A refused requeue on a full ring leaves the offered instruction unchanged.

Other behaviour can only be shown by the bench's scenarios. These cover the number of entries that a kill of a given count removes, the ordering of a requeued instruction against one accepted in the same cycle, and a kill stuck behind a clog.

// File: rtl/iring_pkg.sv
package iring_pkg;
    typedef enum logic [1:0] {
        K_NORM   = 2'b00,
        K_KILL   = 2'b01,
        K_CLOG   = 2'b10,
        K_UNCLOG = 2'b11
    } kind_e;
endpackage

// File: rtl/iring_store.sv
module iring_store #(
    parameter int DEPTH = 8,
    parameter int IW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          rq_push,
    input  logic [IW-1:0] rq_data,
    input  logic          in_push,
    input  logic [IW-1:0] in_data,
    output logic [IW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          s_d, s_q;
    logic [IW-1:0] mem_d [DEPTH];
    logic [IW-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d   = s_q;
        mem_d = mem_q;
        if (pop) begin
            s_d.rd = adv(s_q.rd);
        end
        // a requeued entry takes the insertion slot before a new arrival
        if (rq_push) begin
            mem_d[s_d.wr] = rq_data;
            s_d.wr        = adv(s_d.wr);
        end
        if (in_push) begin
            mem_d[s_d.wr] = in_data;
            s_d.wr        = adv(s_d.wr);
        end
        s_d.cnt = s_q.cnt + CW'(rq_push) + CW'(in_push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q   <= s_d;
            mem_q <= mem_d;
        end
    end

    assign head  = mem_q[s_q.rd];
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |-> !(rq_push || in_push));

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/iring_park.sv
module iring_park
    import iring_pkg::*;
#(
    parameter int KCW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  kind_e          load_kind,
    input  logic [KCW-1:0] load_count,
    input  logic           head_valid,
    input  kind_e          head_kind,
    output logic           busy,
    output logic           kill_wait,
    output logic           kill_take,
    output logic           unclog_take
);
    typedef struct packed {
        logic           busy;
        logic           is_kill;
        logic [KCW-1:0] left;
    } park_t;

    park_t p_d, p_q;

    always_comb begin
        p_d         = p_q;
        kill_take   = p_q.busy && p_q.is_kill && head_valid && (head_kind != K_CLOG);
        unclog_take = p_q.busy && !p_q.is_kill && head_valid && (head_kind == K_CLOG);
        if (kill_take) begin
            if (p_q.left == '0) begin
                p_d.busy = 1'b0;
            end else begin
                p_d.left = p_q.left - 1'b1;
            end
        end
        if (unclog_take) begin
            p_d.busy = 1'b0;
        end
        if (load) begin
            p_d.busy    = 1'b1;
            p_d.is_kill = (load_kind == K_KILL);
            p_d.left    = load_count;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign busy      = p_q.busy;
    assign kill_wait = p_q.busy && p_q.is_kill;

    // R6
    kill_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_take && p_q.left == '0) |=> !busy);

    // R6
    kill_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_take && p_q.left != '0) |=> kill_wait);

    // R5
    unclog_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unclog_take |=> !busy);
endmodule

// File: rtl/instr_ring.sv
module instr_ring
    import iring_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = 16,
    parameter int KCW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [IW-1:0] in_instr,
    output logic          exec_valid,
    output logic [IW-1:0] exec_instr,
    input  logic          exec_retire,
    input  logic          exec_requeue
);
    logic [IW-1:0] head;
    logic          empty, full;
    logic          parked, kill_wait, kill_take, unclog_take;
    kind_e         head_kind, in_kind;
    logic          head_valid, in_fire, in_special;
    logic          do_retire, do_requeue, pop;

    assign head_kind  = kind_e'(head[IW-1 -: 2]);
    assign in_kind    = kind_e'(in_instr[IW-1 -: 2]);
    assign head_valid = !empty;

    assign in_ready   = !full && !parked;
    assign in_fire    = in_valid && in_ready;
    assign in_special = (in_kind == K_KILL) || (in_kind == K_UNCLOG);

    assign exec_valid = head_valid && (head_kind == K_NORM) && !kill_wait;
    assign exec_instr = head;
    assign do_retire  = exec_valid && exec_retire;
    assign do_requeue = exec_valid && exec_requeue && !exec_retire && !full;
    assign pop        = do_retire || do_requeue || kill_take || unclog_take;

    iring_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop     (pop),
        .rq_push (do_requeue),
        .rq_data (head),
        .in_push (in_fire && !in_special),
        .in_data (in_instr),
        .head    (head),
        .empty   (empty),
        .full    (full)
    );

    iring_park #(.KCW(KCW)) u_park (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (in_fire && in_special),
        .load_kind   (in_kind),
        .load_count  (in_instr[KCW-1:0]),
        .head_valid  (head_valid),
        .head_kind   (head_kind),
        .busy        (parked),
        .kill_wait   (kill_wait),
        .kill_take   (kill_take),
        .unclog_take (unclog_take)
    );

    // R4 R7
    clog_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && head_kind == K_CLOG && !unclog_take)
        |=> (head_valid && head_kind == K_CLOG));

    // R9
    full_requeue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && exec_valid && exec_requeue && !exec_retire)
        |=> (exec_valid && $stable(exec_instr)));
endmodule

// File: tb/instr_ring_test.sv
module instr_ring_test;
    localparam int DEPTH = 8;
    localparam int IW    = 16;
    localparam int KCW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [IW-1:0] in_instr = '0;
    logic          exec_valid;
    logic [IW-1:0] exec_instr;
    logic          exec_retire = 1'b0;
    logic          exec_requeue = 1'b0;

    int    n_tests = 0;
    int    n_fail  = 0;
    string phase   = "R1";
    bit    last_fire;

    logic [IW-1:0] mq[$];
    bit            pk_busy, pk_kill;
    int            pk_left;

    always #4 clk = ~clk;

    instr_ring #(.DEPTH(DEPTH), .IW(IW), .KCW(KCW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .exec_valid(exec_valid), .exec_instr(exec_instr),
        .exec_retire(exec_retire), .exec_requeue(exec_requeue)
    );

    function automatic logic [IW-1:0] mk(input logic [1:0] k, input int v);
        return {k, (IW-2)'(v)};
    endfunction

    function automatic bit exp_ready();
        return (mq.size() < DEPTH) && !pk_busy;
    endfunction

    function automatic bit exp_valid();
        return (mq.size() > 0) && (mq[0][IW-1 -: 2] == 2'b00) && !(pk_busy && pk_kill);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s (%s): actual %0h expected %0h", tag, phase, got, exp);
        end
    endtask

    task automatic model_edge(input bit v, input logic [IW-1:0] x, input bit ret, input bit rq);
        int            sz   = mq.size();
        bit            hv   = sz > 0;
        logic [1:0]    hk   = hv ? mq[0][IW-1 -: 2] : 2'b00;
        bit            fire = v && exp_ready();
        bit            ev   = exp_valid();
        bit            kt   = pk_busy && pk_kill && hv && hk != 2'b10;
        bit            ut   = pk_busy && !pk_kill && hv && hk == 2'b10;
        bit            rt   = ev && ret;
        bit            rqq  = ev && rq && !ret && sz < DEPTH;
        logic [IW-1:0] h    = '0;
        if (kt || ut || rt || rqq) h = mq.pop_front();
        if (rqq) mq.push_back(h);
        if (kt) begin
            if (pk_left == 0) pk_busy = 0;
            else pk_left--;
        end
        if (ut) pk_busy = 0;
        if (fire) begin
            if (x[IW-1 -: 2] == 2'b01 || x[IW-1 -: 2] == 2'b11) begin
                pk_busy = 1;
                pk_kill = (x[IW-1 -: 2] == 2'b01);
                pk_left = int'(x[KCW-1:0]);
            end else begin
                mq.push_back(x);
            end
        end
        last_fire = fire;
    endtask

    task automatic step(input bit v, input logic [IW-1:0] x, input bit ret, input bit rq);
        in_valid = v; in_instr = x; exec_retire = ret; exec_requeue = rq;
        #1;
        chk("R10", 32'(in_ready), 32'(exp_ready()));
        chk("R3", 32'(exec_valid), 32'(exp_valid()));
        if (exp_valid()) chk("R3", 32'(exec_instr), 32'(mq[0]));
        @(posedge clk);
        model_edge(v, x, ret, rq);
        @(negedge clk);
        in_valid = 0; exec_retire = 0; exec_requeue = 0;
    endtask

    task automatic put(input logic [IW-1:0] x);
        for (int g = 0; g < 50; g++) begin
            step(1, x, 0, 0);
            if (last_fire) break;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0);
    endtask

    task automatic do_reset();
        in_valid = 0; exec_retire = 0; exec_requeue = 0;
        rst_n = 0;
        mq.delete(); pk_busy = 0; pk_kill = 0; pk_left = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    function automatic logic [IW-1:0] rnd_instr();
        int r = int'($urandom % 32);
        if (r < 2) return mk(2'b10, 0);
        if (r < 5) return mk(2'b11, 0);
        if (r < 7) return mk(2'b01, int'($urandom % 3));
        return mk(2'b00, int'($urandom));
    endfunction

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        #1;
        phase = "R1";
        chk("R1", 32'(in_ready), 32'd1);
        chk("R1", 32'(exec_valid), 32'd0);

        phase = "R3 random";
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) != 0, rnd_instr(), ($urandom % 3) == 0, ($urandom % 5) == 0);

        do_reset();
        phase = "R6 kill0";
        put(mk(0, 'h11)); put(mk(0, 'h12)); put(mk(0, 'h13));
        put(mk(2'b01, 0));
        #1;
        chk("R6", 32'(in_ready), 32'd0);
        chk("R6", 32'(exec_valid), 32'd0);
        idle(2);
        #1;
        chk("R6", 32'(exec_valid), 32'd1);
        chk("R6", 32'(exec_instr), 32'(mk(0, 'h12)));
        chk("R6", 32'(in_ready), 32'd1);

        phase = "R6 kill3";
        put(mk(0, 'h14)); put(mk(0, 'h15)); put(mk(0, 'h16));
        put(mk(2'b01, 3));
        idle(5);
        #1;
        chk("R2", 32'(exec_instr), 32'(mk(0, 'h16)));
        chk("R6", 32'(in_ready), 32'd1);
        step(0, '0, 1, 0);
        #1;
        chk("R6", 32'(exec_valid), 32'd0);

        phase = "R4 late unclog";
        put(mk(2'b10, 0)); put(mk(0, 'h21));
        idle(3);
        #1;
        chk("R4", 32'(exec_valid), 32'd0);
        put(mk(2'b11, 0));
        idle(1);
        #1;
        chk("R5", 32'(exec_valid), 32'd1);
        chk("R5", 32'(exec_instr), 32'(mk(0, 'h21)));
        step(0, '0, 1, 0);

        phase = "R5 unclog waits";
        put(mk(0, 'h31)); put(mk(2'b10, 0)); put(mk(0, 'h32)); put(mk(2'b11, 0));
        #1;
        chk("R5", 32'(in_ready), 32'd0);
        chk("R5", 32'(exec_instr), 32'(mk(0, 'h31)));
        idle(2);
        #1;
        chk("R5", 32'(in_ready), 32'd0);
        step(0, '0, 1, 0);
        idle(1);
        #1;
        chk("R5", 32'(exec_instr), 32'(mk(0, 'h32)));
        chk("R5", 32'(in_ready), 32'd1);
        step(0, '0, 1, 0);

        phase = "R8 requeue order";
        put(mk(0, 'h41)); put(mk(0, 'h42)); put(mk(0, 'h43));
        step(1, mk(0, 'h44), 0, 1);
        #1; chk("R8", 32'(exec_instr), 32'(mk(0, 'h42))); step(0, '0, 1, 0);
        #1; chk("R8", 32'(exec_instr), 32'(mk(0, 'h43))); step(0, '0, 1, 0);
        #1; chk("R8", 32'(exec_instr), 32'(mk(0, 'h41))); step(0, '0, 1, 0);
        #1; chk("R8", 32'(exec_instr), 32'(mk(0, 'h44))); step(0, '0, 1, 0);

        phase = "R9 full ring";
        for (int i = 0; i < DEPTH; i++) put(mk(0, 'h50 + i));
        #1;
        chk("R10", 32'(in_ready), 32'd0);
        step(0, '0, 0, 1);
        #1;
        chk("R9", 32'(exec_instr), 32'(mk(0, 'h50)));
        step(0, '0, 1, 1);
        #1;
        chk("R11", 32'(exec_instr), 32'(mk(0, 'h51)));
        chk("R11", 32'(in_ready), 32'd1);

        do_reset();
        phase = "R7 kill behind clog";
        put(mk(2'b10, 0)); put(mk(0, 'h61)); put(mk(2'b01, 0));
        idle(4);
        #1;
        chk("R7", 32'(in_ready), 32'd0);
        chk("R7", 32'(exec_valid), 32'd0);
        do_reset();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule